// File: doc/BRIEF.md
# DMA Buffer Port with Hardware Read-Clear

This block sits between a multi-pipe packet buffer and a DMA engine. It holds one selected pipe. It raises a transfer request while that pipe's buffer is ready for the port. It counts the bytes that the DMA engine moves, one or two per accepted beat, depending on the access width.

When the port reads received packets, the block decides whether the pipe buffer must be cleared once the data has been drained. With hardware clearing enabled, it always issues a one-clock clear pulse. With hardware clearing disabled, it raises a status telling software that a manual clear is needed. It does this only for the packet endings that leave stale state behind. The decision uses the way the packet ended and a per-pipe block-read flag.

The DMA side is a request/acknowledge handshake:

- `dma_req` plays the role of valid and `dma_ack` the role of ready.
- A beat moves only in a cycle where both are high.
- The request stays asserted while the engine holds off, so back-pressure simply stretches the transfer.
- Packet-end events are single-cycle strobes with no back-pressure.

Top module: `dma_fifo_port`

## Requirements
- R1: Only pipe numbers 1 to 9 (NUM_PIPES-1) can be served; while pipe 0 or any number above 9 is selected, `dma_req` stays low.
- R2: `dma_req` is high exactly when a legal pipe is selected, that pipe's `buf_rdy` bit is high, and no clear hold is active.
- R3: Each accepted beat (`dma_req` and `dma_ack` both high) adds 1 byte to `byte_cnt` when `wide_sel`=0 and 2 bytes when `wide_sel`=1. In the read direction, the beat that brings the count to at least the packet length completes the read and returns `byte_cnt` to 0.
- R4: The port is busy while a read is pending or `byte_cnt` is non-zero. A change of `pipe_sel` while busy sets the sticky `sel_err` and leaves the served pipe unchanged.
- R5: With `read_dir`=0, `buf_clr` is never asserted, and a packet-end event returns `byte_cnt` to 0.
- R6: With `read_dir`=1 and `auto_clr_en`=1, every completed read issues a `buf_clr` pulse. This holds for every ending code and for either block-read value. The ending codes on `pkt_end_kind` are 0 full buffer, 1 zero-length, 2 short, 3 transaction-count end.
- R7: With `auto_clr_en`=0, a completed read sets `sw_clr_req` as follows:
  - never after a full buffer;
  - always after a zero-length packet;
  - after a short packet or a count end only when the served pipe's `blk_read` bit is 1.
  
  The status is cleared by the next packet-end event.
- R8: A zero-length packet moves no data. With hardware clearing enabled, its `buf_clr` pulse appears in the cycle right after the event, without any acknowledge.
- R9: `buf_clr` lasts one clock. `dma_req` is low during it and stays low until the pipe's `buf_rdy` has been seen low and then rises again.
- R10: A synchronous reset returns the block to idle: no request, no clear, no status, no error, count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pipe_sel | input | PIPE_W | Requested pipe number |
| wide_sel | input | 1 | Access width: 0 = 8-bit, 1 = 16-bit |
| read_dir | input | 1 | 1 = port reads the buffer, 0 = port writes it |
| auto_clr_en | input | 1 | Enable hardware clear after reads |
| blk_read | input | NUM_PIPES | Per-pipe block-read flag |
| buf_rdy | input | NUM_PIPES | Per-pipe buffer ready for the port |
| pkt_end_valid | input | 1 | Packet-end strobe for the served pipe |
| pkt_end_kind | input | 2 | Ending code (0 full, 1 zero-length, 2 short, 3 count end) |
| pkt_len | input | LEN_W | Received packet length in bytes |
| dma_ack | input | 1 | DMA beat acknowledge |
| dma_req | output | 1 | DMA transfer request |
| buf_clr | output | 1 | One-clock buffer clear pulse |
| sw_clr_req | output | 1 | Manual clear needed status |
| sel_err | output | 1 | Sticky illegal pipe change flag |
| byte_cnt | output | LEN_W | Bytes moved in the current packet |

## Verification
The bench builds the block with ten pipes, so the illegal selections are pipe 0 and codes 10 to 15. It also shrinks the length field to 8 bits, which keeps each packet to a handful of beats.

These settings bring several cases within reach in a short run:
- every combination of the four ending codes, the block-read flag and the clear enable;
- both access widths, including an odd length drained by 16-bit beats;
- the clear hold that lasts until a ready toggle;
- a pipe change in the middle of a pending read.

// File: rtl/fifo_dma_pkg.sv
package fifo_dma_pkg;

  typedef enum logic [1:0] {
    END_FULL  = 2'd0,
    END_ZLP   = 2'd1,
    END_SHORT = 2'd2,
    END_TCNT  = 2'd3
  } end_kind_e;

  // Manual-clear policy when hardware clearing is off.
  function automatic logic manual_clear_needed(end_kind_e kind, logic blk);
    case (kind)
      END_FULL: return 1'b0;
      END_ZLP:  return 1'b1;
      default:  return blk;
    endcase
  endfunction

endpackage

// File: rtl/dma_pipe_select.sv
module dma_pipe_select #(
  parameter int PIPE_W    = 4,
  parameter int NUM_PIPES = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [PIPE_W-1:0]    pipe_sel,
  input  logic                 busy,
  output logic [PIPE_W-1:0]    cur_pipe,
  output logic                 pipe_ok,
  output logic [NUM_PIPES-1:0] pipe_hot,
  output logic                 sel_err
);
  localparam int MAX_PIPE = NUM_PIPES - 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_pipe <= '0;
      sel_err  <= 1'b0;
    end else if (busy) begin
      if (pipe_sel != cur_pipe) sel_err <= 1'b1;
    end else begin
      cur_pipe <= pipe_sel;
    end
  end

  assign pipe_ok = (cur_pipe >= PIPE_W'(1)) && (cur_pipe <= PIPE_W'(MAX_PIPE));

  for (genvar g = 0; g < NUM_PIPES; g++) begin : g_hot
    assign pipe_hot[g] = (cur_pipe == PIPE_W'(g));
  end

  assert_err_only_busy_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(sel_err) |-> $past(busy));

  assert_pipe_held_R4: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(cur_pipe));

endmodule

// File: rtl/dma_byte_counter.sv
module dma_byte_counter #(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wide,
  input  logic             acc,
  input  logic             clr,
  output logic [LEN_W-1:0] byte_cnt,
  output logic [LEN_W:0]   cnt_next
);
  assign cnt_next = {1'b0, byte_cnt} + (wide ? (LEN_W+1)'(2) : (LEN_W+1)'(1));

  always_ff @(posedge clk) begin
    if (rst || clr) byte_cnt <= '0;
    else if (acc)   byte_cnt <= cnt_next[LEN_W-1:0];
  end

  assert_idle_count_R3: assert property (@(posedge clk) disable iff (rst)
    (!acc && !clr) |=> $stable(byte_cnt));

endmodule

// File: rtl/dma_clear_policy.sv
module dma_clear_policy
  import fifo_dma_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      read_dir,
  input  logic      auto_clr_en,
  input  logic      done,
  input  end_kind_e done_kind,
  input  logic      done_blk,
  input  logic      pkt_evt,
  output logic      buf_clr,
  output logic      sw_clr_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      buf_clr    <= 1'b0;
      sw_clr_req <= 1'b0;
    end else begin
      buf_clr <= done && read_dir && auto_clr_en;
      if (done && read_dir && !auto_clr_en && manual_clear_needed(done_kind, done_blk))
        sw_clr_req <= 1'b1;
      else if (pkt_evt)
        sw_clr_req <= 1'b0;
    end
  end

  assert_write_no_clr_R5: assert property (@(posedge clk) disable iff (rst)
    buf_clr |-> $past(read_dir));

  assert_sw_only_manual_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(sw_clr_req) |-> $past(!auto_clr_en));

endmodule

// File: rtl/dma_fifo_port.sv
module dma_fifo_port
  import fifo_dma_pkg::*;
#(
  parameter int PIPE_W    = 4,
  parameter int NUM_PIPES = 10,
  parameter int LEN_W     = 11
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [PIPE_W-1:0]    pipe_sel,
  input  logic                 wide_sel,
  input  logic                 read_dir,
  input  logic                 auto_clr_en,
  input  logic [NUM_PIPES-1:0] blk_read,
  input  logic [NUM_PIPES-1:0] buf_rdy,
  input  logic                 pkt_end_valid,
  input  logic [1:0]           pkt_end_kind,
  input  logic [LEN_W-1:0]     pkt_len,
  input  logic                 dma_ack,
  output logic                 dma_req,
  output logic                 buf_clr,
  output logic                 sw_clr_req,
  output logic                 sel_err,
  output logic [LEN_W-1:0]     byte_cnt
);
  logic [PIPE_W-1:0]    cur_pipe;
  logic                 pipe_ok;
  logic [NUM_PIPES-1:0] pipe_hot;
  logic [LEN_W:0]       cnt_next;
  logic                 busy, rdy_sel, blk_sel, accept, pkt_evt;
  logic                 rd_done, zlp_done, done, cnt_clr, clr_set;
  logic                 rd_pending, blocked;
  logic [LEN_W-1:0]     rd_len;
  end_kind_e            rd_kind, evt_kind, done_kind;

  assign evt_kind = end_kind_e'(pkt_end_kind);
  assign busy     = rd_pending || (byte_cnt != '0);

  dma_pipe_select #(.PIPE_W(PIPE_W), .NUM_PIPES(NUM_PIPES)) u_sel (
    .clk(clk), .rst(rst), .pipe_sel(pipe_sel), .busy(busy),
    .cur_pipe(cur_pipe), .pipe_ok(pipe_ok), .pipe_hot(pipe_hot), .sel_err(sel_err)
  );

  assign rdy_sel = |(buf_rdy & pipe_hot);
  assign blk_sel = |(blk_read & pipe_hot);
  assign dma_req = pipe_ok && rdy_sel && !blocked;
  assign accept  = dma_req && dma_ack;
  assign pkt_evt = pkt_end_valid && pipe_ok;

  assign rd_done   = read_dir && rd_pending && accept && (cnt_next >= {1'b0, rd_len});
  assign zlp_done  = pkt_evt && read_dir && (evt_kind == END_ZLP);
  assign done      = rd_done || zlp_done;
  assign done_kind = zlp_done ? END_ZLP : rd_kind;
  assign cnt_clr   = rd_done || (pkt_evt && !read_dir);
  assign clr_set   = done && read_dir && auto_clr_en;

  dma_byte_counter #(.LEN_W(LEN_W)) u_cnt (
    .clk(clk), .rst(rst), .wide(wide_sel), .acc(accept), .clr(cnt_clr),
    .byte_cnt(byte_cnt), .cnt_next(cnt_next)
  );

  dma_clear_policy u_pol (
    .clk(clk), .rst(rst), .read_dir(read_dir), .auto_clr_en(auto_clr_en),
    .done(done), .done_kind(done_kind), .done_blk(blk_sel), .pkt_evt(pkt_evt),
    .buf_clr(buf_clr), .sw_clr_req(sw_clr_req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pending <= 1'b0;
      rd_len     <= '0;
      rd_kind    <= END_FULL;
    end else if (pkt_evt && read_dir && (evt_kind != END_ZLP)) begin
      rd_pending <= 1'b1;
      rd_len     <= pkt_len;
      rd_kind    <= evt_kind;
    end else if (rd_done) begin
      rd_pending <= 1'b0;
    end
  end

  // Clear hold: set by a clear, released once ready is seen low.
  always_ff @(posedge clk) begin
    if (rst)          blocked <= 1'b0;
    else if (clr_set) blocked <= 1'b1;
    else if (!rdy_sel) blocked <= 1'b0;
  end

  assert_clr_drops_req_R9: assert property (@(posedge clk) disable iff (rst)
    buf_clr |-> !dma_req);

  assert_no_req_pipe0_R1: assert property (@(posedge clk) disable iff (rst)
    ($past(pipe_sel) == '0 && !$past(busy)) |-> !dma_req);

  assert_req_needs_rdy_R2: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> (buf_rdy != '0));

endmodule

// File: tb/tb_dma_fifo_port.sv
module tb_dma_fifo_port;
  localparam int PIPE_W = 4, NUM_PIPES = 10, LEN_W = 8;
  localparam int EXP_CLR = 1, EXP_SW = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic [PIPE_W-1:0] pipe_sel = '0;
  logic wide_sel = 0, read_dir = 0, auto_clr_en = 0;
  logic [NUM_PIPES-1:0] blk_read = '0, buf_rdy = '0;
  logic pkt_end_valid = 0;
  logic [1:0] pkt_end_kind = '0;
  logic [LEN_W-1:0] pkt_len = '0;
  logic dma_ack = 0;
  logic dma_req, buf_clr, sw_clr_req, sel_err;
  logic [LEN_W-1:0] byte_cnt;

  int tests = 0, fails = 0;
  int exp_q[$];
  logic sw_prev = 1'b0;

  always #5 clk = ~clk;

  dma_fifo_port #(.PIPE_W(PIPE_W), .NUM_PIPES(NUM_PIPES), .LEN_W(LEN_W)) dut (
    .clk(clk), .rst(rst), .pipe_sel(pipe_sel), .wide_sel(wide_sel), .read_dir(read_dir),
    .auto_clr_en(auto_clr_en), .blk_read(blk_read), .buf_rdy(buf_rdy),
    .pkt_end_valid(pkt_end_valid), .pkt_end_kind(pkt_end_kind), .pkt_len(pkt_len),
    .dma_ack(dma_ack), .dma_req(dma_req), .buf_clr(buf_clr), .sw_clr_req(sw_clr_req),
    .sel_err(sel_err), .byte_cnt(byte_cnt)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Monitor: every clear pulse and every rising status pops one expected item.
  always @(negedge clk) begin
    if (!rst) begin
      if (buf_clr) begin
        check("R6 clear pulse expected", (exp_q.size() > 0) ? exp_q[0] : 0, EXP_CLR);
        if (exp_q.size() > 0) void'(exp_q.pop_front());
        check("R9 request low during clear", int'(dma_req), 0);
      end
      if (sw_clr_req && !sw_prev) begin
        check("R7 manual clear expected", (exp_q.size() > 0) ? exp_q[0] : 0, EXP_SW);
        if (exp_q.size() > 0) void'(exp_q.pop_front());
      end
      sw_prev = sw_clr_req;
    end
  end

  // Driver: one received packet on pipe 3, drained to completion.
  task automatic run_read(input int kind, input int len, input bit wide,
                          input bit blk, input bit autoc, input int exp_code);
    int s, words;
    read_dir = 1; wide_sel = wide; auto_clr_en = autoc; blk_read[3] = blk;
    buf_rdy = '0; step(); buf_rdy[3] = 1'b1;
    if (exp_code != 0) exp_q.push_back(exp_code);
    pkt_end_valid = 1; pkt_end_kind = 2'(kind); pkt_len = LEN_W'(len);
    step();
    pkt_end_valid = 0;
    if (kind == 1) begin
      if (autoc) check("R8 zero-length clear next cycle", int'(buf_clr), 1);
    end else begin
      s = wide ? 2 : 1;
      words = (len + s - 1) / s;
      for (int i = 0; i < words; i++) begin
        dma_ack = 1; step();
        check("R3 byte count", int'(byte_cnt), (i == words - 1) ? 0 : (i + 1) * s);
      end
      dma_ack = 0;
    end
    step(); step();
    check("R6/R7 outcome consumed", exp_q.size(), 0);
    if (exp_code == 0) check("R7 no clear action", int'(buf_clr) + int'(sw_clr_req), 0);
  endtask

  initial begin
    repeat (3) step();
    check("R10 reset req", int'(dma_req), 0);
    check("R10 reset clr", int'(buf_clr) + int'(sw_clr_req) + int'(sel_err), 0);
    check("R10 reset count", int'(byte_cnt), 0);
    rst = 0;

    // R1 / R2
    buf_rdy = '1; pipe_sel = 0; step(); step();
    check("R1 pipe 0 no request", int'(dma_req), 0);
    pipe_sel = 12; step(); step();
    check("R1 pipe 12 no request", int'(dma_req), 0);
    pipe_sel = 9; step(); step();
    check("R1 pipe 9 requests", int'(dma_req), 1);
    pipe_sel = 3; buf_rdy = '0; buf_rdy[3] = 1; step(); step();
    check("R2 request with ready", int'(dma_req), 1);
    buf_rdy[3] = 0; step();
    check("R2 no request without ready", int'(dma_req), 0);

    // R6 / R9: hardware clearing, every ending code
    run_read(0, 4, 0, 0, 1, EXP_CLR);
    check("R9 held after clear", int'(dma_req), 0);
    buf_rdy[3] = 0; step(); buf_rdy[3] = 1; step();
    check("R9 request back after ready toggle", int'(dma_req), 1);
    run_read(2, 6, 1, 1, 1, EXP_CLR);
    run_read(3, 5, 1, 0, 1, EXP_CLR);
    run_read(1, 0, 0, 1, 1, EXP_CLR);

    // R7: manual policy table
    run_read(0, 3, 0, 1, 0, 0);
    run_read(1, 0, 0, 0, 0, EXP_SW);
    run_read(2, 2, 0, 0, 0, 0);
    run_read(2, 3, 1, 1, 0, EXP_SW);
    run_read(3, 2, 0, 0, 0, 0);
    run_read(3, 4, 1, 1, 0, EXP_SW);

    // R5: write direction
    read_dir = 0; auto_clr_en = 1; wide_sel = 0;
    buf_rdy = '0; step(); buf_rdy[3] = 1;
    for (int i = 0; i < 3; i++) begin dma_ack = 1; step(); end
    dma_ack = 0;
    check("R5 write count", int'(byte_cnt), 3);
    pkt_end_valid = 1; pkt_end_kind = 2; step(); pkt_end_valid = 0;
    check("R5 write end resets count", int'(byte_cnt), 0);
    step();
    check("R5 no clear in write", int'(buf_clr), 0);

    // R4: pipe change while a read is pending
    read_dir = 1; auto_clr_en = 0; blk_read = '0;
    pkt_end_valid = 1; pkt_end_kind = 0; pkt_len = 4; step(); pkt_end_valid = 0;
    pipe_sel = 5; buf_rdy = '0; buf_rdy[3] = 1; step(); step();
    check("R4 error flag", int'(sel_err), 1);
    check("R4 pipe kept", int'(dma_req), 1);
    for (int i = 0; i < 4; i++) begin dma_ack = 1; step(); end
    dma_ack = 0;
    check("R4 old pipe drained", int'(byte_cnt), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule